// File: doc/BRIEF.md
# Pseudo-Random Serial Lane Transmitter

This block is a test-pattern transmitter for a single serial lane. A 15-bit linear feedback shift register, clocked by a slow word clock, produces eight fresh pattern bits per word-clock cycle and packs them into a byte. A serializer running on a bit clock four times faster sends that byte out on both edges of the bit clock, which yields eight bits per word-clock period.

An optional polarity flip XORs the serial stream before the output pair. This lets a board whose lane pins are swapped be corrected in logic while the true and complement outputs keep their proper roles. The differential output is modelled as a true bit and its complement. Both clocks must come from one source with their rising edges aligned. Reset must be released so that the first bit-clock rising edge after release coincides with a word-clock rising edge.

Top module: `prbs_lane_tx`

## Requirements
- R1: While `rst_n` is low, `tx_p` is 0 and `tx_n` is 1 whatever the value of `invert`.
- R2: During the first word-clock period after reset release, measured from the first aligned rising edge, the serial data is all zeros, so `tx_p` equals `invert`.
- R3: The pattern state is 15 bits, with seed 15'h0001 by default (polynomial x^15 + x^14 + 1). Each step computes new = s[14] ^ s[13] and sets s = {s[13:0], new}. Eight steps run per word-clock cycle, and the first new bit of a cycle becomes bit 7 of that cycle's byte.
- R4: Byte n (n = 0 for the first byte after reset) is sent during word-clock period n + 1, most significant bit first. Each bit lasts half a bit-clock period. The high half of a bit-clock period carries bits 7, 5, 3, 1 and the low half carries bits 6, 4, 2, 0.
- R5: `tx_p` equals the serial bit XOR `invert`. A change of `invert` takes effect at once, with no clock delay.
- R6: `tx_n` is always the complement of `tx_p`.
- R7: The pattern state never becomes zero, and the serial bit stream repeats with a period of 32767 bits.
- R8: Asserting reset in the middle of the stream and releasing it again restarts the sequence from the seed, beginning with a zero-filled word period as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; both edges move one serial bit |
| clk_word | input | 1 | Word clock, bit clock divided by four, rising edges aligned |
| rst_n | input | 1 | Asynchronous reset, active low |
| invert | input | 1 | Polarity flip of the serial data, 1 = inverted |
| tx_p | output | 1 | True output of the lane |
| tx_n | output | 1 | Complement output of the lane |

## Verification
Each byte becomes visible one full word-clock period after the word edge that computes it: one edge loads the generator register, and the next aligned edge loads the serializer. Each bit is then visible from the bit-clock edge that starts its half period. The bench keeps a timeline referenced to each aligned word edge and samples every bit 2 ns into its 5 ns slot, well clear of any edge. The polarity flip is combinational, so the bench changes it 1 ns after a word edge and expects it to act from the next sample onward. The reset checks are taken while reset is still held.

// File: rtl/prbs_lane_pkg.sv
package prbs_lane_pkg;
    // Widths and feedback tap positions of the pattern generator.
    localparam int GEN_W    = 15;
    localparam int TAP_A    = 14;
    localparam int TAP_B    = 13;
    localparam int BYTE_W   = 8;
    localparam logic [GEN_W-1:0] GEN_SEED = 15'h0001;
endpackage

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
    import prbs_lane_pkg::*;
#(
    parameter int               STATE_W = GEN_W,
    parameter int               WORD_W  = BYTE_W,
    parameter int               TAP_HI  = TAP_A,
    parameter int               TAP_LO  = TAP_B,
    parameter logic [STATE_W-1:0] SEED  = GEN_SEED
) (
    input  logic              clk_word,
    input  logic              rst_n,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [STATE_W-1:0] lfsr;
        logic [WORD_W-1:0]  word;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        logic [STATE_W-1:0] s;
        logic               fb;
        s  = st_q.lfsr;
        fb = 1'b0;
        st_d = st_q;
        for (int i = 0; i < WORD_W; i++) begin
            fb = s[TAP_HI] ^ s[TAP_LO];
            s  = {s[STATE_W-2:0], fb};
            st_d.word[WORD_W-1-i] = fb;
        end
        st_d.lfsr = s;
    end

    always_ff @(posedge clk_word or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= SEED;
            st_q.word <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

    AST_STATE_LIVE: assert property (@(posedge clk_word) disable iff (!rst_n)
        st_q.lfsr != '0); // R7

    AST_WORD_IS_TAIL: assert property (@(posedge clk_word) disable iff (!rst_n)
        1'b1 |=> (word_o == st_q.lfsr[WORD_W-1:0])); // R3
endmodule

// File: rtl/prbs_ddr_ser.sv
module prbs_ddr_ser
    import prbs_lane_pkg::*;
#(
    parameter int WORD_W = BYTE_W
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);
    localparam int PAIRS  = WORD_W / 2;
    localparam int PH_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int REST_W = WORD_W - 2;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [REST_W-1:0] rest;
        logic [1:0]        pair;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == '0) begin
            st_d.pair = word_i[WORD_W-1 -: 2];
            st_d.rest = word_i[REST_W-1:0];
        end else begin
            st_d.pair = st_q.rest[REST_W-1 -: 2];
            st_d.rest = st_q.rest << 2;
        end
        if (st_q.phase == PH_W'(PAIRS - 1))
            st_d.phase = '0;
        else
            st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Double data rate output: high half sends the earlier bit of the pair.
    assign bit_o = clk_bit ? st_q.pair[1] : st_q.pair[0];

    AST_PHASE_WRAP: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (st_q.phase == PH_W'(PAIRS - 1)) |=> (st_q.phase == '0)); // R4

    AST_LOAD_TOP_PAIR: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (st_q.phase == '0) |=> (st_q.pair == $past(word_i[WORD_W-1 -: 2]))); // R4
endmodule

// File: rtl/prbs_lane_tx.sv
module prbs_lane_tx
    import prbs_lane_pkg::*;
#(
    parameter logic [GEN_W-1:0] SEED = GEN_SEED
) (
    input  logic clk_bit,
    input  logic clk_word,
    input  logic rst_n,
    input  logic invert,
    output logic tx_p,
    output logic tx_n
);
    logic [BYTE_W-1:0] word;
    logic              ser_bit;
    logic              line;

    prbs_word_gen #(
        .STATE_W (GEN_W),
        .WORD_W  (BYTE_W),
        .TAP_HI  (TAP_A),
        .TAP_LO  (TAP_B),
        .SEED    (SEED)
    ) u_gen (
        .clk_word (clk_word),
        .rst_n    (rst_n),
        .word_o   (word)
    );

    prbs_ddr_ser #(
        .WORD_W (BYTE_W)
    ) u_ser (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .word_i  (word),
        .bit_o   (ser_bit)
    );

    // Polarity is flipped on the data, ahead of the output pair.
    assign line = ser_bit ^ invert;
    assign tx_p = rst_n & line;
    assign tx_n = ~tx_p;

    AST_RESET_HOLDS_ZERO: assert property (@(posedge clk_bit)
        (!rst_n) |-> (tx_p == 1'b0 && tx_n == 1'b1)); // R1
endmodule

// File: tb/sim_prbs_lane_tx.sv
`timescale 1ns/100ps
module sim_prbs_lane_tx;
    localparam logic [14:0] SEED   = 15'h0001;
    localparam int          NWORDS = 4240;
    localparam int          PERIOD = 32767;
    localparam int          WIN    = 1024;

    logic clk_bit, clk_word, rst_n, invert;
    logic tx_p, tx_n;
    int   tests, fails, edge_cnt;
    bit   done;
    logic head [0:WIN-1];
    logic tail [0:WIN-1];

    prbs_lane_tx #(.SEED(SEED)) u0 (
        .clk_bit (clk_bit), .clk_word (clk_word), .rst_n (rst_n),
        .invert (invert), .tx_p (tx_p), .tx_n (tx_n)
    );

    initial begin
        clk_bit = 0; clk_word = 0; edge_cnt = 0;
    end
    always begin
        #5 clk_bit = ~clk_bit;
        if (clk_bit) begin
            if (edge_cnt % 2 == 0) clk_word = ~clk_word;
            edge_cnt++;
        end
    end

    function automatic logic [7:0] model_byte(input logic [14:0] s);
        logic [7:0] b;
        logic       f;
        for (int i = 0; i < 8; i++) begin
            f = s[14] ^ s[13];
            s = {s[13:0], f};
            b[7-i] = f;
        end
        return b;
    endfunction

    function automatic logic [14:0] model_adv(input logic [14:0] s);
        for (int i = 0; i < 8; i++) s = {s[13:0], s[14] ^ s[13]};
        return s;
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("[TB] FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
        end
    endtask

    // Waits to 2 ns before an aligned word edge, releases reset, ends on the edge.
    task automatic release_aligned();
        @(posedge clk_word);
        #38 rst_n = 1;
        #2;
    endtask

    // One zero-filled word period; starts and ends on a word edge.
    task automatic fill_word(input string req);
        #2;
        for (int j = 0; j < 8; j++) begin
            check(tx_p, invert, req);
            check(tx_n, ~invert, "R6");
            if (j < 7) #5;
        end
        #3;
    endtask

    task automatic pattern_word(input logic [7:0] b, input logic inv,
                                input string req, input int base_idx, input bit keep);
        logic got;
        #1 invert = inv;
        #1;
        for (int j = 0; j < 8; j++) begin
            check(tx_p, b[7-j] ^ inv, req);
            check(tx_n, ~tx_p, "R6");
            got = tx_p ^ inv;
            if (keep) begin
                if (base_idx + j < WIN) head[base_idx + j] = got;
                if (base_idx + j >= PERIOD && base_idx + j < PERIOD + WIN)
                    tail[base_idx + j - PERIOD] = got;
            end
            if (j < 7) #5;
        end
        #3;
    endtask

    initial begin
        logic [14:0] m;
        logic        inv;
        tests = 0; fails = 0; done = 0;
        rst_n = 0; invert = 1;
        void'($urandom(32'd4242));

        // R1: reset holds the pair quiet even with the flip on.
        repeat (3) @(posedge clk_word);
        for (int k = 0; k < 4; k++) begin
            #7;
            check(tx_p, 1'b0, "R1");
            check(tx_n, 1'b1, "R1");
        end

        invert = 0;
        release_aligned();
        fill_word("R2");

        m = SEED;
        for (int n = 0; n < NWORDS; n++) begin
            if (n < 2)      inv = 1'b0;
            else if (n < 4) inv = 1'b1;
            else            inv = 1'($urandom % 2);
            pattern_word(model_byte(m), inv, inv ? "R5" : "R3 R4", n * 8, 1'b1);
            m = model_adv(m);
        end

        // R7: stream repeats after 32767 bits.
        for (int i = 0; i < WIN; i++) check(tail[i], head[i], "R7");

        // R8: reset in mid-word, then restart from seed.
        #13 rst_n = 0;
        #1 invert = 1;
        #1;
        check(tx_p, 1'b0, "R8");
        check(tx_n, 1'b1, "R8");
        release_aligned();
        fill_word("R8");
        m = SEED;
        for (int n = 0; n < 4; n++) begin
            pattern_word(model_byte(m), n[0], "R8", 0, 1'b0);
            m = model_adv(m);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++; fails++;
            $display("[TB] FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule